// File: doc/BRIEF.md
# Complex Feedback-Only Decision Equalizer

This block cancels post-cursor multipath from a stream of complex baseband samples on a single-carrier, constant-envelope link. It has only a feedback filter. Each of the NTAPS complex taps is weighted by a past hard decision of plus or minus one on each rail, so every tap contributes an add or a subtract of its coefficient components, with no multiplier. The summed echo estimate is subtracted from the incoming sample, and the result is saturated to the sample width. The equalizer sits after carrier phase correction, so the samples reaching the later coarse quantizer have less dynamic range.

One sample arrives per symbol with a valid strobe. For every accepted sample the block produces the equalized sample, the two sign decisions and the error against the ideal constellation level. Coefficients are loaded one tap at a time through a write port. When adaptation is enabled they also follow a sign-error LMS rule on every accepted sample. Samples can arrive back to back, because a decision enters the history in the same cycle as its sample.

Top module: `cdfe_feedback_eq`

## Requirements
- R1: After a synchronous reset, all outputs are zero, every coefficient is zero and every stored decision reads as +1 (encoding 0).
- R2: `out_valid` is high exactly on the second rising edge after an edge that captured `in_valid` high, with one output per accepted sample and none otherwise.
- R3: With all coefficients zero, the equalized sample equals the input sample on both rails.
- R4: The equalized sample is x minus the sum over taps k of c_k times d_k, in complex arithmetic. Here c_k = a_k + j·b_k is the coefficient of tap k and d_k is the decision pair from k+1 accepted samples earlier. Decision bit 0 means +1 and bit 1 means -1. The real part is a·di - b·dq and the imaginary part is a·dq + b·di.
- R5: The equalized sample saturates to the DW-bit signed range (-128..127 by default) instead of wrapping.
- R6: The decision bit of a rail is 1 exactly when that rail's equalized sample is negative. A value of zero gives 0.
- R7: The error of a rail is eq - DEC_LEVEL when its decision bit is 0, and eq + DEC_LEVEL when it is 1, carried in DW+1 signed bits.
- R8: Stored decisions shift only on accepted samples, so idle cycles between samples do not change the result.
- R9: A write with `coef_we` high loads tap `coef_addr` with (`coef_wr_i`, `coef_wr_q`). An address of NTAPS or more changes nothing. A write beats an adaptation of the same tap in the same cycle.
- R10: With `adapt_en` high, each accepted sample updates every tap, and the result saturates to the CW-bit signed range. The update is a += s·(sI·di + sQ·dq) and b += s·(sQ·di - sI·dq). Here s is `step`, sI and sQ are the signs of the errors (+1 when the error is at least zero), and di and dq are the decisions used by that tap for this sample.
- R11: With `adapt_en` low and no write, the coefficients keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | AW | Tap index to write |
| coef_wr_i | input | CW | Real coefficient part to write, signed |
| coef_wr_q | input | CW | Imaginary coefficient part to write, signed |
| adapt_en | input | 1 | Enables sign-error LMS adaptation |
| step | input | STEPW | Adaptation step size, unsigned |
| out_valid | output | 1 | Output strobe |
| out_eq_i | output | DW | Equalized in-phase sample |
| out_eq_q | output | DW | Equalized quadrature sample |
| out_dec_i | output | 1 | In-phase decision (1 = negative) |
| out_dec_q | output | 1 | Quadrature decision (1 = negative) |
| out_err_i | output | DW+1 | In-phase slicer error |
| out_err_q | output | DW+1 | Quadrature slicer error |

## Verification
A full sweep of every in-phase input value with zero taps shows that the pass-through path, the slicer at zero and the error offsets are right. Pseudo-random streams with small mixed-sign taps check the sign pattern of the complex feedback, and would catch a swapped rail or a conjugated product. Full-scale taps push the sum into saturation, and streams with random gaps show that the history shifts only on accepted samples. Adaptation runs with two step sizes, one of them large enough to clip the coefficients. Further streams cover writes to an out-of-range address, a write colliding with adaptation, and frozen coefficients after adaptation is switched off.

// File: rtl/cdfe_pkg.sv
package cdfe_pkg;
  // decision pair: bit set means the rail was negative (-1)
  typedef struct packed {
    logic neg_i;
    logic neg_q;
  } dec_pair_t;
endpackage

// File: rtl/cdfe_dec_hist.sv
module cdfe_dec_hist #(
  parameter int NTAPS = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  cdfe_pkg::dec_pair_t   din,
  output logic [NTAPS-1:0]      hist_i,
  output logic [NTAPS-1:0]      hist_q
);
  // bit 0 holds the newest decision
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
    end else if (shift_en) begin
      hist_i <= {hist_i[NTAPS-2:0], din.neg_i};
      hist_q <= {hist_q[NTAPS-2:0], din.neg_q};
    end
  end
endmodule

// File: rtl/cdfe_fb_sum.sv
module cdfe_fb_sum #(
  parameter int NTAPS = 15,
  parameter int CW    = 8,
  parameter int SUMW  = 14
) (
  input  logic [NTAPS*CW-1:0]    coef_i,
  input  logic [NTAPS*CW-1:0]    coef_q,
  input  logic [NTAPS-1:0]       hist_i,
  input  logic [NTAPS-1:0]       hist_q,
  output logic signed [SUMW-1:0] fb_i,
  output logic signed [SUMW-1:0] fb_q
);
  localparam int TW = CW + 2;

  logic signed [TW-1:0] term_re [NTAPS];
  logic signed [TW-1:0] term_im [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_term
    logic signed [TW-1:0] a, b;
    assign a = {{2{coef_i[k*CW+CW-1]}}, coef_i[k*CW +: CW]};
    assign b = {{2{coef_q[k*CW+CW-1]}}, coef_q[k*CW +: CW]};
    // real: a*di - b*dq ; imag: a*dq + b*di
    assign term_re[k] = (hist_i[k] ? -a : a) + (hist_q[k] ? b : -b);
    assign term_im[k] = (hist_q[k] ? -a : a) + (hist_i[k] ? -b : b);
  end

  always_comb begin
    fb_i = '0;
    fb_q = '0;
    for (int k = 0; k < NTAPS; k++) begin
      fb_i = fb_i + {{(SUMW-TW){term_re[k][TW-1]}}, term_re[k]};
      fb_q = fb_q + {{(SUMW-TW){term_im[k][TW-1]}}, term_im[k]};
    end
  end
endmodule

// File: rtl/cdfe_slicer.sv
module cdfe_slicer #(
  parameter int DW    = 8,
  parameter int SUMW  = 14,
  parameter int LEVEL = 64,
  localparam int EW   = DW + 1
) (
  input  logic signed [DW-1:0]   x,
  input  logic signed [SUMW-1:0] fb,
  output logic signed [DW-1:0]   y,
  output logic                   dec,
  output logic signed [EW-1:0]   err
);
  localparam int DFW = SUMW + 1;
  localparam logic signed [DFW-1:0] YMAX = DFW'(2**(DW-1) - 1);
  localparam logic signed [DFW-1:0] YMIN = -YMAX - DFW'(1);
  localparam logic signed [EW-1:0]  LV   = EW'(LEVEL);

  logic signed [DFW-1:0] x_ext, fb_ext, diff;
  logic signed [EW-1:0]  y_ext;

  always_comb begin
    x_ext  = {{(DFW-DW){x[DW-1]}}, x};
    fb_ext = {fb[SUMW-1], fb};
    diff   = x_ext - fb_ext;
    if (diff > YMAX)      y = YMAX[DW-1:0];
    else if (diff < YMIN) y = YMIN[DW-1:0];
    else                  y = diff[DW-1:0];
    dec   = y[DW-1];
    y_ext = {y[DW-1], y};
    err   = dec ? (y_ext + LV) : (y_ext - LV);
  end
endmodule

// File: rtl/cdfe_tap_bank.sv
module cdfe_tap_bank #(
  parameter int NTAPS = 15,
  parameter int CW    = 8,
  parameter int STEPW = 4,
  parameter int AW    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_i,
  input  logic signed [CW-1:0] wr_q,
  input  logic                 upd_en,
  input  logic [STEPW-1:0]     step,
  input  logic                 err_neg_i,
  input  logic                 err_neg_q,
  input  logic [NTAPS-1:0]     hist_i,
  input  logic [NTAPS-1:0]     hist_q,
  output logic [NTAPS*CW-1:0]  coef_i,
  output logic [NTAPS*CW-1:0]  coef_q
);
  localparam int UW = CW + 2;
  localparam logic signed [UW-1:0] CMAX = UW'(2**(CW-1) - 1);
  localparam logic signed [UW-1:0] CMIN = -CMAX - UW'(1);

  logic signed [UW-1:0] stp;
  assign stp = {{(UW-STEPW){1'b0}}, step};

  function automatic logic signed [CW-1:0] clip(input logic signed [UW-1:0] v);
    if (v > CMAX)      return CMAX[CW-1:0];
    else if (v < CMIN) return CMIN[CW-1:0];
    else               return v[CW-1:0];
  endfunction

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [CW-1:0] ci, cq;
    logic signed [UW-1:0] ui, uq, ni, nq;
    logic                 hit;

    assign hit = wr_en && (wr_addr == AW'(k));

    always_comb begin
      // sign(e) * conj(d): equal sign bits mean a positive product
      ui = ((err_neg_i == hist_i[k]) ? stp : -stp)
         + ((err_neg_q == hist_q[k]) ? stp : -stp);
      uq = ((err_neg_q == hist_i[k]) ? stp : -stp)
         + ((err_neg_i == hist_q[k]) ? -stp : stp);
      ni = {{2{ci[CW-1]}}, ci} + ui;
      nq = {{2{cq[CW-1]}}, cq} + uq;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ci <= '0;
        cq <= '0;
      end else if (hit) begin
        ci <= wr_i;
        cq <= wr_q;
      end else if (upd_en) begin
        ci <= clip(ni);
        cq <= clip(nq);
      end
    end

    assign coef_i[k*CW +: CW] = ci;
    assign coef_q[k*CW +: CW] = cq;
  end
endmodule

// File: rtl/cdfe_feedback_eq.sv
module cdfe_feedback_eq #(
  parameter int DW        = 8,
  parameter int CW        = 8,
  parameter int NTAPS     = 15,
  parameter int STEPW     = 4,
  parameter int DEC_LEVEL = 64,
  localparam int AW       = $clog2(NTAPS),
  localparam int EW       = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic signed [CW-1:0] coef_wr_i,
  input  logic signed [CW-1:0] coef_wr_q,
  input  logic                 adapt_en,
  input  logic [STEPW-1:0]     step,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_eq_i,
  output logic signed [DW-1:0] out_eq_q,
  output logic                 out_dec_i,
  output logic                 out_dec_q,
  output logic signed [EW-1:0] out_err_i,
  output logic signed [EW-1:0] out_err_q
);
  localparam int SUMW = CW + 1 + $clog2(2 * NTAPS);

  logic [NTAPS-1:0]      hist_i_w, hist_q_w;
  logic [NTAPS*CW-1:0]   coef_i_w, coef_q_w;
  logic signed [SUMW-1:0] fb_i, fb_q;
  logic signed [DW-1:0]  y_i, y_q;
  logic                  dec_i, dec_q;
  logic signed [EW-1:0]  e_i, e_q;
  cdfe_pkg::dec_pair_t   dec_now;

  cdfe_fb_sum #(.NTAPS(NTAPS), .CW(CW), .SUMW(SUMW)) u_fb (
    .coef_i(coef_i_w), .coef_q(coef_q_w),
    .hist_i(hist_i_w), .hist_q(hist_q_w),
    .fb_i(fb_i), .fb_q(fb_q)
  );

  cdfe_slicer #(.DW(DW), .SUMW(SUMW), .LEVEL(DEC_LEVEL)) u_sl_i (
    .x(in_i), .fb(fb_i), .y(y_i), .dec(dec_i), .err(e_i)
  );

  cdfe_slicer #(.DW(DW), .SUMW(SUMW), .LEVEL(DEC_LEVEL)) u_sl_q (
    .x(in_q), .fb(fb_q), .y(y_q), .dec(dec_q), .err(e_q)
  );

  assign dec_now = '{neg_i: dec_i, neg_q: dec_q};

  cdfe_dec_hist #(.NTAPS(NTAPS)) u_hist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(dec_now),
    .hist_i(hist_i_w), .hist_q(hist_q_w)
  );

  cdfe_tap_bank #(.NTAPS(NTAPS), .CW(CW), .STEPW(STEPW), .AW(AW)) u_taps (
    .clk(clk), .rst(rst),
    .wr_en(coef_we), .wr_addr(coef_addr), .wr_i(coef_wr_i), .wr_q(coef_wr_q),
    .upd_en(in_valid && adapt_en), .step(step),
    .err_neg_i(e_i[EW-1]), .err_neg_q(e_q[EW-1]),
    .hist_i(hist_i_w), .hist_q(hist_q_w),
    .coef_i(coef_i_w), .coef_q(coef_q_w)
  );

  // stage 1: capture of the slicer result
  logic                 v1;
  logic signed [DW-1:0] y1_i, y1_q;
  logic                 d1_i, d1_q;
  logic signed [EW-1:0] e1_i, e1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      y1_i <= '0;
      y1_q <= '0;
      d1_i <= 1'b0;
      d1_q <= 1'b0;
      e1_i <= '0;
      e1_q <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        y1_i <= y_i;
        y1_q <= y_q;
        d1_i <= dec_i;
        d1_q <= dec_q;
        e1_i <= e_i;
        e1_q <= e_q;
      end
    end
  end

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_eq_i  <= '0;
      out_eq_q  <= '0;
      out_dec_i <= 1'b0;
      out_dec_q <= 1'b0;
      out_err_i <= '0;
      out_err_q <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_eq_i  <= y1_i;
        out_eq_q  <= y1_q;
        out_dec_i <= d1_i;
        out_dec_q <= d1_q;
        out_err_i <= e1_i;
        out_err_q <= e1_q;
      end
    end
  end
endmodule

// File: rtl/cdfe_feedback_eq_chk.sv
module cdfe_feedback_eq_chk #(
  parameter int DW        = 8,
  parameter int CW        = 8,
  parameter int NTAPS     = 15,
  parameter int DEC_LEVEL = 64,
  localparam int EW       = DW + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                adapt_en,
  input logic                coef_we,
  input logic                out_valid,
  input logic [DW-1:0]       out_eq_i,
  input logic                out_dec_i,
  input logic [EW-1:0]       out_err_i,
  input logic [NTAPS-1:0]    hist_i,
  input logic [NTAPS-1:0]    hist_q,
  input logic [NTAPS*CW-1:0] coef_i,
  input logic [NTAPS*CW-1:0] coef_q
);
  localparam logic signed [EW-1:0] LV = EW'(DEC_LEVEL);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2: two-edge latency, one output per accepted sample
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R7: error offset follows the decision
  assert_err_offset_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_err_i) ==
      ($signed({out_eq_i[DW-1], out_eq_i}) + (out_dec_i ? LV : -LV))));

  // R8: history holds on idle cycles
  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(hist_i) && $stable(hist_q)));

  // R11: coefficients hold without write or adaptation
  assert_coef_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!coef_we && !(in_valid && adapt_en)) |=> ($stable(coef_i) && $stable(coef_q)));
endmodule

bind cdfe_feedback_eq cdfe_feedback_eq_chk #(
  .DW(DW), .CW(CW), .NTAPS(NTAPS), .DEC_LEVEL(DEC_LEVEL)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .adapt_en(adapt_en),
  .coef_we(coef_we), .out_valid(out_valid), .out_eq_i(out_eq_i),
  .out_dec_i(out_dec_i), .out_err_i(out_err_i),
  .hist_i(hist_i_w), .hist_q(hist_q_w), .coef_i(coef_i_w), .coef_q(coef_q_w)
);

// File: tb/cdfe_feedback_eq_tb.sv
module cdfe_feedback_eq_tb_top;
  localparam int NT = 15;
  localparam int LV = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_i = '0, in_q = '0;
  logic              coef_we = 1'b0;
  logic [3:0]        coef_addr = '0;
  logic signed [7:0] coef_wr_i = '0, coef_wr_q = '0;
  logic              adapt_en = 1'b0;
  logic [3:0]        step = '0;
  logic              out_valid;
  logic signed [7:0] out_eq_i, out_eq_q;
  logic              out_dec_i, out_dec_q;
  logic signed [8:0] out_err_i, out_err_q;

  cdfe_feedback_eq dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wr_i(coef_wr_i),
    .coef_wr_q(coef_wr_q), .adapt_en(adapt_en), .step(step),
    .out_valid(out_valid), .out_eq_i(out_eq_i), .out_eq_q(out_eq_q),
    .out_dec_i(out_dec_i), .out_dec_q(out_dec_q),
    .out_err_i(out_err_i), .out_err_q(out_err_q)
  );

  int tests = 0, fails = 0;
  string tag = "R3";
  bit en_chk = 1'b0;
  bit nx_adapt = 1'b0;
  int nx_step = 0;
  bit [31:0] seed = 32'h1234_5678;

  int ca[NT], cb[NT];
  bit hi[NT], hq[NT];

  bit cur_v = 0, prev_v = 0;
  int cur_yi, cur_yq, cur_ei, cur_eq, prev_yi, prev_yq, prev_ei, prev_eq;
  bit cur_di, cur_dq, prev_di, prev_dq;

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  function automatic int sat(input int v, input int lo, input int hh);
    if (v > hh) return hh;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int fi, fq, yi, yq, ei, eq, si, sq, dvi, dvq, na, nb;
    bit di, dq;
    prev_v = cur_v; prev_yi = cur_yi; prev_yq = cur_yq;
    prev_di = cur_di; prev_dq = cur_dq; prev_ei = cur_ei; prev_eq = cur_eq;
    if (rst) begin
      for (int k = 0; k < NT; k++) begin ca[k] = 0; cb[k] = 0; hi[k] = 0; hq[k] = 0; end
      cur_v = 0;
      return;
    end
    fi = 0; fq = 0;
    for (int k = 0; k < NT; k++) begin
      fi += (hi[k] ? -ca[k] : ca[k]) + (hq[k] ? cb[k] : -cb[k]);
      fq += (hq[k] ? -ca[k] : ca[k]) + (hi[k] ? -cb[k] : cb[k]);
    end
    yi = sat(int'(in_i) - fi, -128, 127);
    yq = sat(int'(in_q) - fq, -128, 127);
    di = yi < 0; dq = yq < 0;
    ei = yi - (di ? -LV : LV);
    eq = yq - (dq ? -LV : LV);
    si = (ei >= 0) ? 1 : -1;
    sq = (eq >= 0) ? 1 : -1;
    for (int k = 0; k < NT; k++) begin
      if (coef_we && int'(coef_addr) == k) begin
        ca[k] = int'(coef_wr_i); cb[k] = int'(coef_wr_q);
      end else if (in_valid && adapt_en) begin
        dvi = hi[k] ? -1 : 1; dvq = hq[k] ? -1 : 1;
        na = ca[k] + int'(step) * (si * dvi + sq * dvq);
        nb = cb[k] + int'(step) * (sq * dvi - si * dvq);
        ca[k] = sat(na, -128, 127); cb[k] = sat(nb, -128, 127);
      end
    end
    if (in_valid) begin
      for (int k = NT - 1; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
      hi[0] = di; hq[0] = dq;
    end
    cur_v = in_valid; cur_yi = yi; cur_yq = yq;
    cur_di = di; cur_dq = dq; cur_ei = ei; cur_eq = eq;
  endtask

  task automatic check_outputs();
    if (!en_chk) return;
    chk(out_valid == prev_v, "R2", "out_valid", int'(out_valid), int'(prev_v));
    if (prev_v) begin
      chk(int'(out_eq_i) == prev_yi, tag, "eq_i", int'(out_eq_i), prev_yi);
      chk(int'(out_eq_q) == prev_yq, tag, "eq_q", int'(out_eq_q), prev_yq);
      chk(out_dec_i == prev_di, "R6", "dec_i", int'(out_dec_i), int'(prev_di));
      chk(out_dec_q == prev_dq, "R6", "dec_q", int'(out_dec_q), int'(prev_dq));
      chk(int'(out_err_i) == prev_ei, "R7", "err_i", int'(out_err_i), prev_ei);
      chk(int'(out_err_q) == prev_eq, "R7", "err_q", int'(out_err_q), prev_eq);
    end
  endtask

  task automatic cyc(input bit v, input int xi, input int xq,
                     input bit we = 1'b0, input int addr = 0,
                     input int wi = 0, input int wq = 0);
    @(negedge clk);
    check_outputs();
    in_valid = v; in_i = xi[7:0]; in_q = xq[7:0];
    coef_we = we; coef_addr = addr[3:0];
    coef_wr_i = wi[7:0]; coef_wr_q = wq[7:0];
    adapt_en = nx_adapt; step = nx_step[3:0];
    @(posedge clk);
    model_edge();
  endtask

  task automatic run_random(input int n, input bit gaps);
    for (int s = 0; s < n; s++) begin
      bit v;
      v = gaps ? rnd8()[0] : 1'b1;
      cyc(v, rnd8(), rnd8());
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) cyc(0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0);
    @(negedge clk);
    // R1: reset state at the ports
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(out_eq_i == 0 && out_eq_q == 0, "R1", "eq", int'(out_eq_i), 0);
    chk(!out_dec_i && !out_dec_q, "R1", "dec", int'(out_dec_i), 0);
    chk(out_err_i == 0 && out_err_q == 0, "R1", "err", int'(out_err_i), 0);
    en_chk = 1'b1;

    // R1: first samples after reset use all-plus history with loaded taps
    tag = "R1";
    for (int k = 0; k < NT; k++) cyc(0, 0, 0, 1, k, k - 7, 3 - k);
    for (int s = 0; s < 4; s++) cyc(1, 10 * s, -20 * s);

    // R3: zero taps, full sweep of the in-phase input
    tag = "R3";
    for (int k = 0; k < NT; k++) cyc(0, 0, 0, 1, k, 0, 0);
    for (int v = -128; v < 128; v++) cyc(1, v, v * 37);

    // R4: small mixed taps, random stream
    tag = "R4";
    for (int k = 0; k < NT; k++) cyc(0, 0, 0, 1, k, rnd8() / 12, rnd8() / 12);
    run_random(200, 1'b0);

    // R5: full-scale taps force saturation
    tag = "R5";
    for (int k = 0; k < NT; k++) cyc(0, 0, 0, 1, k, (k % 2) ? 127 : -128, (k % 3) ? -128 : 127);
    run_random(120, 1'b0);
    cyc(1, 127, -128);
    cyc(1, -128, 127);

    // R8: gaps between samples
    tag = "R8";
    for (int k = 0; k < NT; k++) cyc(0, 0, 0, 1, k, rnd8() / 8, rnd8() / 8);
    run_random(200, 1'b1);

    // R9: out-of-range address, write against adaptation
    tag = "R9";
    cyc(0, 0, 0, 1, 15, 100, -100);
    run_random(20, 1'b0);
    nx_adapt = 1'b1; nx_step = 2;
    cyc(1, 40, -40, 1, 3, 50, -50);
    nx_adapt = 1'b0;
    run_random(30, 1'b0);

    // R10: sign-error adaptation, small then large step
    tag = "R10";
    nx_adapt = 1'b1; nx_step = 3;
    run_random(250, 1'b0);
    nx_step = 15;
    run_random(120, 1'b1);

    // R11: adaptation off, nonzero step has no effect
    tag = "R11";
    nx_adapt = 1'b0;
    run_random(120, 1'b0);

    repeat (3) cyc(0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule